// File: doc/BRIEF.md
# External Bus Arbiter for Core and DMA Channels

This block decides, once per clock, which requester may use a single external bus: the processor core, one of `N_CH` DMA channels, or a DRAM refresh request. Each DMA channel carries a small priority value and a continuous-mode flag. A 2-bit policy field sets how DMA traffic ranks against the core. The field can fix that ranking or ask for a per-cycle comparison between the priority of the competing channel and a core priority input.

Each DMA transfer takes two bus accesses, a source read and then a destination write, and the arbiter tracks which of the two comes next. When a channel has done its source access and the core outranks it, the channel waits with its destination access still pending. It finishes that access before any other channel starts. Grants are registered. A grant visible in a cycle answers the requests sampled at the clock edge that opened that cycle, and it marks one bus access in that cycle.

Top module: `bus_arbiter`

## Requirements
- R1: After reset, and in any cycle whose decision saw no request and no pending destination access, every grant output is 0.
- R2: Grants are registered outputs: the decision uses the inputs sampled at a clock edge and appears in the following cycle. At most one of `gnt_core`, `gnt_ref` and the bits of `gnt_dma` is 1 in any cycle.
- R3: A refresh request wins the next cycle over every other requester, including a channel halted between its accesses and a channel in continuous mode.
- R4: With `bus_mode` = 2'b01 the DMA side outranks the core. While any channel requests or a destination access is pending, the core receives no grant, so it waits until the transfer completes.
- R5: With `bus_mode` = 2'b10 the two sides rank equally. A new transfer starts only when the core is not requesting. Once its source access is done, the destination access is granted ahead of the core.
- R6: With `bus_mode` = 2'b11 the DMA side ranks lower. No channel is granted while the core requests, and this includes a pending destination access, which stays halted.
- R7: With `bus_mode` = 2'b00 the effective channel priority is compared with `core_prio`. Greater acts as R4, equal acts as R5 and smaller acts as R6.
- R8: Every transfer is a source grant followed by a destination grant to the same channel. No other channel is granted between the two; only the core or refresh may be.
- R9: While a channel's destination access is pending, its effective priority is the larger of its own priority and the highest priority among requesting channels. The R7 comparison uses this value.
- R10: At a transfer boundary, channels without a continuous-mode lock are picked by the highest priority value (the field for channel i is `chan_prio[i*PRIO_W +: PRIO_W]`). Ties go to the lowest index.
- R11: A channel with `dma_cont` set that completes a transfer and keeps requesting keeps the DMA side against requesters of equal or lower priority. A requester of strictly higher priority takes the next transfer.
- R12: After a cycle that granted a continuous-mode channel which outranked the core (R4 or R7 greater), the core gets no grant in the next cycle, even when no channel is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 2 | Policy: 00 dynamic, 01 DMA above core, 10 equal, 11 DMA below core |
| core_prio | input | PRIO_W | Core priority used in dynamic policy |
| core_req | input | 1 | Core wants the bus this cycle |
| ref_req | input | 1 | DRAM refresh wants the bus |
| dma_req | input | N_CH | Per-channel transfer request |
| dma_cont | input | N_CH | Per-channel continuous-mode flag |
| chan_prio | input | N_CH*PRIO_W | Packed per-channel priorities |
| gnt_core | output | 1 | Core owns the bus this cycle |
| gnt_ref | output | 1 | Refresh owns the bus this cycle |
| gnt_dma | output | N_CH | One-hot channel grant for this cycle |

## Verification
Every cycle, the bound checker confirms that the grants are at most one-hot, that refresh wins right after it is requested, and that an idle bus grants nothing. It also confirms that the fixed policies keep the core out (DMA above) or keep the channels out (DMA below or equal, at a transfer start), and that the core is locked out in the cycle after a continuous channel that outranks it. Other behaviours depend on history, and only the directed scenarios show them: the source and destination pairing, the priority raise of a halted channel, the lowest-index tie break, and the continuous-mode lock giving way to a strictly higher channel.

// File: rtl/arb_pkg.sv
package arb_pkg;

   localparam int unsigned MAX_PRIO_W = 8;

   typedef enum logic [1:0] {
      POL_DYNAMIC = 2'b00,
      POL_DMA_HI  = 2'b01,
      POL_EQUAL   = 2'b10,
      POL_DMA_LO  = 2'b11
   } bus_policy_e;

   typedef enum logic [1:0] {
      RANK_BELOW = 2'd0,
      RANK_SAME  = 2'd1,
      RANK_ABOVE = 2'd2
   } dma_rank_e;

   function automatic dma_rank_e rank_vs_core(bus_policy_e pol,
                                              logic [MAX_PRIO_W-1:0] dma_p,
                                              logic [MAX_PRIO_W-1:0] core_p);
      dma_rank_e r;
      unique case (pol)
         POL_DMA_HI: r = RANK_ABOVE;
         POL_EQUAL:  r = RANK_SAME;
         POL_DMA_LO: r = RANK_BELOW;
         default: begin
            if (dma_p > core_p)       r = RANK_ABOVE;
            else if (dma_p == core_p) r = RANK_SAME;
            else                      r = RANK_BELOW;
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/arb_chan_pick.sv
module arb_chan_pick #(
   parameter int unsigned N_CH   = 6,
   parameter int unsigned PRIO_W = 2,
   localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic [N_CH-1:0]   req,
   input  logic [PRIO_W-1:0] prio [N_CH],
   output logic              any,
   output logic [IDX_W-1:0]  idx,
   output logic [PRIO_W-1:0] top_prio
);

   generate
      if (N_CH == 1) begin : g_single
         assign any      = req[0];
         assign idx      = '0;
         assign top_prio = req[0] ? prio[0] : '0;
      end else begin : g_scan
         // Scan from the top index down; ">=" lets a lower index take a tie.
         always_comb begin
            any      = 1'b0;
            idx      = '0;
            top_prio = '0;
            for (int i = N_CH - 1; i >= 0; i--) begin
               if (req[i] && (!any || prio[i] >= top_prio)) begin
                  any      = 1'b1;
                  idx      = IDX_W'(i);
                  top_prio = prio[i];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/arb_xfer_track.sv
module arb_xfer_track #(
   parameter int unsigned N_CH = 6,
   localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dma_win,
   input  logic [IDX_W-1:0] win_idx,
   input  logic             win_above,
   input  logic [N_CH-1:0]  dma_req,
   input  logic [N_CH-1:0]  dma_cont,
   output logic             mid_q,
   output logic [IDX_W-1:0] act_q,
   output logic             lock_v_q,
   output logic [IDX_W-1:0] lock_idx_q,
   output logic             hold_q
);

   logic lock_keep;

   assign lock_keep = dma_req[lock_idx_q] && dma_cont[lock_idx_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mid_q      <= 1'b0;
         act_q      <= '0;
         lock_v_q   <= 1'b0;
         lock_idx_q <= '0;
         hold_q     <= 1'b0;
      end else begin
         hold_q <= dma_win && dma_cont[win_idx] && win_above;
         if (dma_win) begin
            if (mid_q) begin
               // Destination access done: transfer ends here.
               mid_q      <= 1'b0;
               lock_v_q   <= dma_cont[win_idx];
               lock_idx_q <= win_idx;
            end else begin
               // Source access done: destination now pending.
               mid_q <= 1'b1;
               act_q <= win_idx;
               if (win_idx != lock_idx_q) lock_v_q <= 1'b0;
            end
         end else if (lock_v_q && !lock_keep) begin
            lock_v_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/arb_decide.sv
module arb_decide
   import arb_pkg::*;
#(
   parameter int unsigned N_CH   = 6,
   parameter int unsigned PRIO_W = 2,
   localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic [1:0]        bus_mode,
   input  logic [PRIO_W-1:0] core_prio,
   input  logic              core_req,
   input  logic              ref_req,
   input  logic [N_CH-1:0]   dma_req,
   input  logic [N_CH-1:0]   dma_cont,
   input  logic [PRIO_W-1:0] prio [N_CH],
   input  logic              pick_any,
   input  logic [IDX_W-1:0]  pick_idx,
   input  logic [PRIO_W-1:0] pick_prio,
   input  logic              mid_q,
   input  logic [IDX_W-1:0]  act_q,
   input  logic              lock_v_q,
   input  logic [IDX_W-1:0]  lock_idx_q,
   input  logic              hold_q,
   output logic              nxt_core,
   output logic              nxt_ref,
   output logic [N_CH-1:0]   nxt_dma,
   output logic              dma_win,
   output logic [IDX_W-1:0]  win_idx,
   output logic              win_above
);

   logic              lock_ok;
   logic              cand_v;
   logic [IDX_W-1:0]  cand_idx;
   logic [PRIO_W-1:0] eff_prio;
   dma_rank_e         rank;
   logic              dma_go;

   assign lock_ok = lock_v_q && dma_req[lock_idx_q] && dma_cont[lock_idx_q]
                    && !(pick_prio > prio[lock_idx_q]);

   always_comb begin
      if (mid_q) begin
         cand_v   = 1'b1;
         cand_idx = act_q;
         // A halted channel inherits the highest competing priority.
         eff_prio = (pick_any && pick_prio > prio[act_q]) ? pick_prio : prio[act_q];
      end else if (lock_ok) begin
         cand_v   = 1'b1;
         cand_idx = lock_idx_q;
         eff_prio = prio[lock_idx_q];
      end else begin
         cand_v   = pick_any;
         cand_idx = pick_idx;
         eff_prio = pick_prio;
      end
   end

   assign rank = rank_vs_core(bus_policy_e'(bus_mode),
                              MAX_PRIO_W'(eff_prio), MAX_PRIO_W'(core_prio));

   always_comb begin
      unique case (rank)
         RANK_ABOVE: dma_go = cand_v;
         RANK_SAME:  dma_go = cand_v && (mid_q || !core_req);
         default:    dma_go = cand_v && !core_req;
      endcase
   end

   always_comb begin
      nxt_core  = 1'b0;
      nxt_ref   = 1'b0;
      nxt_dma   = '0;
      dma_win   = 1'b0;
      win_idx   = cand_idx;
      win_above = (rank == RANK_ABOVE);
      if (ref_req) begin
         nxt_ref = 1'b1;
      end else if (dma_go) begin
         dma_win           = 1'b1;
         nxt_dma[cand_idx] = 1'b1;
      end else if (core_req && !hold_q) begin
         nxt_core = 1'b1;
      end
   end

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
   parameter int unsigned N_CH   = 6,
   parameter int unsigned PRIO_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               bus_mode,
   input  logic [PRIO_W-1:0]        core_prio,
   input  logic                     core_req,
   input  logic                     ref_req,
   input  logic [N_CH-1:0]          dma_req,
   input  logic [N_CH-1:0]          dma_cont,
   input  logic [N_CH*PRIO_W-1:0]   chan_prio,
   output logic                     gnt_core,
   output logic                     gnt_ref,
   output logic [N_CH-1:0]          gnt_dma
);

   localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;

   generate
      if (N_CH < 1 || N_CH > 32) begin : g_bad_nch
         $error("bus_arbiter: N_CH must lie in 1..32");
      end
      if (PRIO_W < 1 || PRIO_W > arb_pkg::MAX_PRIO_W) begin : g_bad_pw
         $error("bus_arbiter: PRIO_W must lie in 1..8");
      end
   endgenerate

   logic [PRIO_W-1:0] prio_a [N_CH];

   generate
      for (genvar g = 0; g < N_CH; g++) begin : g_unpack
         assign prio_a[g] = chan_prio[g*PRIO_W +: PRIO_W];
      end
   endgenerate

   logic              pick_any;
   logic [IDX_W-1:0]  pick_idx;
   logic [PRIO_W-1:0] pick_prio;
   logic              mid_q;
   logic [IDX_W-1:0]  act_q;
   logic              lock_v_q;
   logic [IDX_W-1:0]  lock_idx_q;
   logic              hold_q;
   logic              nxt_core;
   logic              nxt_ref;
   logic [N_CH-1:0]   nxt_dma;
   logic              dma_win;
   logic [IDX_W-1:0]  win_idx;
   logic              win_above;

   arb_chan_pick #(.N_CH(N_CH), .PRIO_W(PRIO_W)) i_pick (
      .req      (dma_req),
      .prio     (prio_a),
      .any      (pick_any),
      .idx      (pick_idx),
      .top_prio (pick_prio)
   );

   arb_decide #(.N_CH(N_CH), .PRIO_W(PRIO_W)) i_decide (
      .bus_mode   (bus_mode),
      .core_prio  (core_prio),
      .core_req   (core_req),
      .ref_req    (ref_req),
      .dma_req    (dma_req),
      .dma_cont   (dma_cont),
      .prio       (prio_a),
      .pick_any   (pick_any),
      .pick_idx   (pick_idx),
      .pick_prio  (pick_prio),
      .mid_q      (mid_q),
      .act_q      (act_q),
      .lock_v_q   (lock_v_q),
      .lock_idx_q (lock_idx_q),
      .hold_q     (hold_q),
      .nxt_core   (nxt_core),
      .nxt_ref    (nxt_ref),
      .nxt_dma    (nxt_dma),
      .dma_win    (dma_win),
      .win_idx    (win_idx),
      .win_above  (win_above)
   );

   arb_xfer_track #(.N_CH(N_CH)) i_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .dma_win    (dma_win),
      .win_idx    (win_idx),
      .win_above  (win_above),
      .dma_req    (dma_req),
      .dma_cont   (dma_cont),
      .mid_q      (mid_q),
      .act_q      (act_q),
      .lock_v_q   (lock_v_q),
      .lock_idx_q (lock_idx_q),
      .hold_q     (hold_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_core <= 1'b0;
         gnt_ref  <= 1'b0;
         gnt_dma  <= '0;
      end else begin
         gnt_core <= nxt_core;
         gnt_ref  <= nxt_ref;
         gnt_dma  <= nxt_dma;
      end
   end

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
   parameter int unsigned N_CH   = 6,
   parameter int unsigned PRIO_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_mode,
   input logic              core_req,
   input logic              ref_req,
   input logic [N_CH-1:0]   dma_req,
   input logic [N_CH-1:0]   dma_cont,
   input logic              xfer_mid,
   input logic              gnt_core,
   input logic              gnt_ref,
   input logic [N_CH-1:0]   gnt_dma
);

   p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gnt_core, gnt_ref, gnt_dma}));

   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_req && !ref_req && dma_req == '0 && !xfer_mid)
      |=> (!gnt_core && !gnt_ref && gnt_dma == '0));

   p_refresh_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |=> gnt_ref);

   p_core_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_mode == 2'b01 && !ref_req && (dma_req != '0 || xfer_mid)) |=> !gnt_core);

   p_start_after_core_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_mode == 2'b10 && core_req && !ref_req && !xfer_mid) |=> gnt_dma == '0);

   p_core_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_mode == 2'b11 && core_req && !ref_req) |=> gnt_dma == '0);

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_hold
         p_cont_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_dma[c] && $past(bus_mode == 2'b01 && dma_cont[c])) |=> !gnt_core);
      end
   endgenerate

endmodule

bind bus_arbiter arb_checker #(.N_CH(N_CH), .PRIO_W(PRIO_W)) i_arb_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_mode (bus_mode),
   .core_req (core_req),
   .ref_req  (ref_req),
   .dma_req  (dma_req),
   .dma_cont (dma_cont),
   .xfer_mid (mid_q),
   .gnt_core (gnt_core),
   .gnt_ref  (gnt_ref),
   .gnt_dma  (gnt_dma)
);

// File: tb/test_bus_arbiter.sv
module test_bus_arbiter;

   localparam int CLK_P  = 10;
   localparam int NC     = 4;
   localparam int PW     = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      bus_mode = 2'b01;
   logic [PW-1:0]   core_prio = '0;
   logic            core_req = 1'b0;
   logic            ref_req = 1'b0;
   logic [NC-1:0]   dma_req = '0;
   logic [NC-1:0]   dma_cont = '0;
   logic [NC*PW-1:0] chan_prio = '0;
   logic            gnt_core;
   logic            gnt_ref;
   logic [NC-1:0]   gnt_dma;

   int checks = 0;
   int errors = 0;

   bus_arbiter #(.N_CH(NC), .PRIO_W(PW)) i_bus_arbiter (
      .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .core_prio(core_prio),
      .core_req(core_req), .ref_req(ref_req), .dma_req(dma_req),
      .dma_cont(dma_cont), .chan_prio(chan_prio),
      .gnt_core(gnt_core), .gnt_ref(gnt_ref), .gnt_dma(gnt_dma)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // expected vector: {core, ref, dma[NC-1:0]}
   task automatic expect_g(string tag, logic c, logic r, logic [NC-1:0] d);
      checks++;
      if ({gnt_core, gnt_ref, gnt_dma} !== {c, r, d}) begin
         errors++;
         $display("FAIL %s: actual core=%b ref=%b dma=%b expected core=%b ref=%b dma=%b",
                  tag, gnt_core, gnt_ref, gnt_dma, c, r, d);
      end
   endtask

   task automatic set_prio(int ch, logic [PW-1:0] p);
      chan_prio[ch*PW +: PW] = p;
   endtask

   task automatic settle_idle();
      core_req = 0; ref_req = 0; dma_req = '0; dma_cont = '0;
      step();
      step();
      expect_g("R1 idle", 0, 0, '0);
   endtask

   task automatic t_reset();
      expect_g("R1 in reset", 0, 0, '0);
      rst_n = 1'b1;
      step();
      expect_g("R1 after reset", 0, 0, '0);
   endtask

   task automatic t_refresh();
      bus_mode = 2'b01; set_prio(0, 1);
      core_req = 1; dma_req = 4'b0001; ref_req = 1;
      step(); expect_g("R3 refresh over all", 0, 1, '0);
      ref_req = 0;
      step(); expect_g("R4 src ch0", 0, 0, 4'b0001);
      ref_req = 1; dma_req = '0;
      step(); expect_g("R3 refresh mid transfer", 0, 1, '0);
      ref_req = 0;
      step(); expect_g("R8 dest ch0 after refresh", 0, 0, 4'b0001);
      step(); expect_g("R4 core after transfer", 1, 0, '0);
      settle_idle();
   endtask

   task automatic t_dma_above();
      bus_mode = 2'b01; core_req = 1; dma_req = 4'b0010;
      step(); expect_g("R4 src over core", 0, 0, 4'b0010);
      dma_req = '0;
      step(); expect_g("R4 dest core stalled", 0, 0, 4'b0010);
      step(); expect_g("R4 core resumes", 1, 0, '0);
      settle_idle();
   endtask

   task automatic t_equal();
      bus_mode = 2'b10; core_req = 1; dma_req = 4'b0100;
      step(); expect_g("R5 core first", 1, 0, '0);
      step(); expect_g("R5 core again", 1, 0, '0);
      core_req = 0;
      step(); expect_g("R5 src in free slot", 0, 0, 4'b0100);
      core_req = 1;
      step(); expect_g("R5 dest ahead of core", 0, 0, 4'b0100);
      dma_req = '0;
      step(); expect_g("R5 core after dest", 1, 0, '0);
      settle_idle();
   endtask

   task automatic t_below();
      bus_mode = 2'b11; core_req = 0; dma_req = 4'b1000;
      step(); expect_g("R6 src when core quiet", 0, 0, 4'b1000);
      core_req = 1;
      step(); expect_g("R6 halted core wins", 1, 0, '0);
      step(); expect_g("R6 still halted", 1, 0, '0);
      core_req = 0; dma_req = '0;
      step(); expect_g("R8 dest finishes", 0, 0, 4'b1000);
      settle_idle();
   endtask

   task automatic t_dynamic();
      bus_mode = 2'b00; core_prio = 2;
      set_prio(0, 1); set_prio(3, 3);
      core_req = 1; dma_req = 4'b0001;
      step(); expect_g("R7 lower dma waits", 1, 0, '0);
      core_req = 0;
      step(); expect_g("R7 src ch0", 0, 0, 4'b0001);
      core_req = 1; dma_req = 4'b1001;
      step(); expect_g("R9 raised dest ch0", 0, 0, 4'b0001);
      dma_req = 4'b1000;
      step(); expect_g("R7 higher ch3 over core", 0, 0, 4'b1000);
      step(); expect_g("R7 ch3 dest", 0, 0, 4'b1000);
      core_prio = 3;
      step(); expect_g("R7 equal core first", 1, 0, '0);
      core_req = 0;
      step(); expect_g("R7 equal src", 0, 0, 4'b1000);
      core_req = 1;
      step(); expect_g("R7 equal dest ahead", 0, 0, 4'b1000);
      dma_req = '0;
      step(); expect_g("R7 core after", 1, 0, '0);
      core_prio = 2; core_req = 0; dma_req = 4'b0001;
      step(); expect_g("R7 lower src", 0, 0, 4'b0001);
      core_req = 1;
      step(); expect_g("R7 lower halted", 1, 0, '0);
      core_req = 0; dma_req = '0;
      step(); expect_g("R7 lower dest", 0, 0, 4'b0001);
      settle_idle();
   endtask

   task automatic t_channel_order();
      bus_mode = 2'b01; core_req = 0;
      set_prio(0, 1); set_prio(1, 2); set_prio(2, 2); set_prio(3, 0);
      dma_req = 4'b0111;
      step(); expect_g("R10 highest lowest index", 0, 0, 4'b0010);
      step(); expect_g("R8 same channel dest", 0, 0, 4'b0010);
      step(); expect_g("R10 tie back to ch1", 0, 0, 4'b0010);
      step(); expect_g("R8 dest ch1", 0, 0, 4'b0010);
      dma_req = 4'b0101;
      step(); expect_g("R10 ch2 over ch0", 0, 0, 4'b0100);
      dma_req = '0;
      step(); expect_g("R8 dest ch2", 0, 0, 4'b0100);
      settle_idle();
   endtask

   task automatic t_continuous();
      bus_mode = 2'b01; core_req = 0;
      set_prio(0, 3); set_prio(1, 2); set_prio(2, 2);
      dma_cont = 4'b0100; dma_req = 4'b0100;
      step(); expect_g("R11 cont src", 0, 0, 4'b0100);
      dma_req = 4'b0110;
      step(); expect_g("R8 cont dest", 0, 0, 4'b0100);
      step(); expect_g("R11 keeps bus vs equal", 0, 0, 4'b0100);
      step(); expect_g("R11 dest again", 0, 0, 4'b0100);
      dma_req = 4'b0111;
      step(); expect_g("R11 strictly higher wins", 0, 0, 4'b0001);
      dma_req = 4'b0010;
      step(); expect_g("R8 ch0 dest", 0, 0, 4'b0001);
      step(); expect_g("R10 ch1 after lock cleared", 0, 0, 4'b0010);
      dma_req = '0;
      step(); expect_g("R8 ch1 dest", 0, 0, 4'b0010);
      settle_idle();
   endtask

   task automatic t_hold(logic cont, string tag);
      bus_mode = 2'b01; core_req = 1; dma_cont = {2'b00, cont, 1'b0};
      dma_req = 4'b0010;
      step(); expect_g({tag, " src"}, 0, 0, 4'b0010);
      dma_req = '0;
      step(); expect_g({tag, " dest"}, 0, 0, 4'b0010);
      step();
      if (cont) expect_g("R12 core denied after cont", 0, 0, '0);
      else      expect_g("R12 core granted without cont", 1, 0, '0);
      step(); expect_g({tag, " core"}, 1, 0, '0);
      settle_idle();
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      step();
      step();
      t_reset();
      t_refresh();
      t_dma_above();
      t_equal();
      t_below();
      t_dynamic();
      t_channel_order();
      t_continuous();
      t_hold(1'b1, "R12 cont");
      t_hold(1'b0, "R12 plain");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule